// File: doc/BRIEF.md
# NRZI Bit-Stuffing Serial Transmitter

This block turns a stream of packet bytes into a single-ended serial line for a low/full-speed serial bus. Bytes arrive over a valid/ready handshake. The block advances by one bit time on each cycle where `bit_en` is high. A packet starts when a byte is offered while the block is idle. The block first sends a fixed synchronisation byte. It then sends each payload byte with the lowest-numbered bit first.

After every run of six ones the block inserts a zero. The run count carries across byte boundaries. The block then NRZI-codes the resulting stream. The packet closes with two bit times of single-ended zero and one bit time of the idle level, after which the line driver is released.

The source marks the final byte with `in_last`. If the source has no byte ready when one is needed, the packet closes at that point.

Top module: `usb_nrzi_tx`

## Requirements
- R1: While reset is asserted and right after it, `tx_oe`=0, `tx_level`=1, `tx_se0`=0, `busy`=0 and `in_ready`=0.
- R2: On a bit tick in idle with `in_valid`=1, the packet starts. The first eight bit times carry the sync value 80h least significant bit first, which is seven zeros then a one. NRZI coding starts from the high level. Idle ticks with `in_valid`=0 start nothing.
- R3: Each payload byte is sent bit 0 first. `in_ready` is high only on the bit tick where the previous byte's last bit has gone out. On that tick the byte is taken and its bit 0 is driven.
- R4: NRZI coding: a 0 bit inverts `tx_level` and a 1 bit leaves it unchanged. `tx_oe`=1 and `tx_se0`=0 while bits are sent.
- R5: When six ones in a row have been sent, the next bit time carries an inserted 0 before any further bit. The run is counted across byte boundaries and from the sync byte's final one. The inserted 0 clears the run.
- R6: `in_ready` is low on any bit tick that carries an inserted 0.
- R7: After the last bit, including any pending inserted 0, the line shows two bit times of `tx_se0`=1 with `tx_level`=0 and `tx_oe`=1. Then comes one bit time of `tx_level`=1 and `tx_se0`=0. Then `tx_oe` drops to 0.
- R8: If no byte is offered on a tick where one is needed and no byte was marked last, that tick begins the end-of-packet sequence. `in_ready` is 1 on that tick.
- R9: `busy` is 1 from the starting tick until the tick that releases `tx_oe`.
- R10: On cycles with `bit_en`=0, the line outputs do not change and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One bit time per high cycle |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte value |
| in_last | input | 1 | Offered byte is the final one |
| in_ready | output | 1 | Byte taken on this cycle |
| tx_level | output | 1 | NRZI line level (1 = idle) |
| tx_se0 | output | 1 | Single-ended zero being driven |
| tx_oe | output | 1 | Line driver enable |
| busy | output | 1 | Packet in progress |

## Verification
Two functions can land on the same bit tick: the zero insertion and the handoff of the next byte. The same clash occurs between a pending inserted zero and the start of the closing sequence. A byte such as FCh ends with six ones, which forces an inserted zero exactly where the next byte or the closing sequence would begin. The bench drives such bytes directly and also biases its random bytes toward long runs of ones. For every tick it predicts whether `in_ready` must be low, whether the next tick takes the byte, and the exact line level. It then compares each of these at the ports.

// File: rtl/usb_nrzi_pkg.sv
package usb_nrzi_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_DATA,
      ST_EOP
   } tx_state_e;

   typedef enum logic [2:0] {
      CMD_HOLD,
      CMD_BIT,
      CMD_SE0,
      CMD_J,
      CMD_OFF
   } line_cmd_e;

endpackage

// File: rtl/usb_nrzi_shifter.sv
module usb_nrzi_shifter #(
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-2:0] load_data_i,
   input  logic              shift_i,
   output logic              bit_o,
   output logic              empty_o
);
   logic [DATA_W-2:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         sh_q  <= load_data_i;
         cnt_q <= CNT_W'(DATA_W - 1);
      end else if (shift_i) begin
         sh_q  <= sh_q >> 1;
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign bit_o   = sh_q[0];
   assign empty_o = (cnt_q == '0);

   AST_SHIFT_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i |-> !empty_o); // R3
endmodule

// File: rtl/usb_nrzi_line_enc.sv
module usb_nrzi_line_enc
   import usb_nrzi_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  line_cmd_e cmd_i,
   input  logic      bit_i,
   input  logic      first_i,
   output logic      level_o,
   output logic      se0_o,
   output logic      oe_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_o <= 1'b1;
         se0_o   <= 1'b0;
         oe_o    <= 1'b0;
      end else begin
         case (cmd_i)
            CMD_BIT: begin
               level_o <= (first_i ? 1'b1 : level_o) ^ ~bit_i;
               se0_o   <= 1'b0;
               oe_o    <= 1'b1;
            end
            CMD_SE0: begin
               level_o <= 1'b0;
               se0_o   <= 1'b1;
               oe_o    <= 1'b1;
            end
            CMD_J: begin
               level_o <= 1'b1;
               se0_o   <= 1'b0;
               oe_o    <= 1'b1;
            end
            CMD_OFF: begin
               level_o <= 1'b1;
               se0_o   <= 1'b0;
               oe_o    <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   AST_ZERO_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_BIT && !bit_i && !first_i) |=> (level_o != $past(level_o))); // R4
   AST_ONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_BIT && bit_i && !first_i) |=> $stable(level_o)); // R4
   AST_FIRST_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_BIT && first_i) |=> (level_o == $past(bit_i))); // R2
   AST_SE0_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      se0_o |-> (oe_o && !level_o)); // R7
endmodule

// File: rtl/usb_nrzi_tx.sv
module usb_nrzi_tx
   import usb_nrzi_pkg::*;
#(
   parameter int                DATA_W       = 8,
   parameter int                STUFF_LEN    = 6,
   parameter int                EOP_SE0_BITS = 2,
   parameter logic [DATA_W-1:0] SYNC_VALUE   = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   output logic              in_ready,
   output logic              tx_level,
   output logic              tx_se0,
   output logic              tx_oe,
   output logic              busy
);
   localparam int ONES_W = $clog2(STUFF_LEN + 1);
   localparam int EOP_W  = $clog2(EOP_SE0_BITS + 2);

   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (STUFF_LEN < 1) begin : g_bad_stuff
      $error("STUFF_LEN must be at least 1");
   end
   if (EOP_SE0_BITS < 1) begin : g_bad_eop
      $error("EOP_SE0_BITS must be at least 1");
   end

   tx_state_e         state_q, state_n;
   logic [ONES_W-1:0] ones_q, ones_n;
   logic [EOP_W-1:0]  eop_q, eop_n;
   logic              last_q, last_n;
   line_cmd_e         cmd;
   logic              cmd_bit, cmd_first;
   logic              sh_load, sh_shift, sh_bit, sh_empty;
   logic [DATA_W-2:0] sh_data;
   logic              stuff_due;

   assign stuff_due = (ones_q == ONES_W'(STUFF_LEN));
   assign in_ready  = bit_en && (state_q == ST_DATA) && sh_empty && !stuff_due && !last_q;
   assign busy      = (state_q != ST_IDLE);

   always_comb begin
      state_n   = state_q;
      ones_n    = ones_q;
      eop_n     = eop_q;
      last_n    = last_q;
      cmd       = CMD_HOLD;
      cmd_bit   = 1'b0;
      cmd_first = 1'b0;
      sh_load   = 1'b0;
      sh_shift  = 1'b0;
      sh_data   = in_data[DATA_W-1:1];
      if (bit_en) begin
         case (state_q)
            ST_IDLE: if (in_valid) begin
               cmd       = CMD_BIT;
               cmd_bit   = SYNC_VALUE[0];
               cmd_first = 1'b1;
               sh_load   = 1'b1;
               sh_data   = SYNC_VALUE[DATA_W-1:1];
               ones_n    = SYNC_VALUE[0] ? ONES_W'(1) : '0;
               last_n    = 1'b0;
               state_n   = ST_DATA;
            end
            ST_DATA: begin
               if (stuff_due) begin
                  cmd     = CMD_BIT;
                  cmd_bit = 1'b0;
                  ones_n  = '0;
               end else if (!sh_empty) begin
                  cmd      = CMD_BIT;
                  cmd_bit  = sh_bit;
                  sh_shift = 1'b1;
                  ones_n   = sh_bit ? ones_q + 1'b1 : '0;
               end else if (!last_q && in_valid) begin
                  cmd     = CMD_BIT;
                  cmd_bit = in_data[0];
                  sh_load = 1'b1;
                  last_n  = in_last;
                  ones_n  = in_data[0] ? ones_q + 1'b1 : '0;
               end else begin
                  cmd     = CMD_SE0;
                  eop_n   = EOP_W'(1);
                  state_n = ST_EOP;
               end
            end
            ST_EOP: begin
               if (eop_q < EOP_W'(EOP_SE0_BITS)) begin
                  cmd   = CMD_SE0;
                  eop_n = eop_q + 1'b1;
               end else if (eop_q == EOP_W'(EOP_SE0_BITS)) begin
                  cmd   = CMD_J;
                  eop_n = eop_q + 1'b1;
               end else begin
                  cmd     = CMD_OFF;
                  eop_n   = '0;
                  ones_n  = '0;
                  state_n = ST_IDLE;
               end
            end
            default: state_n = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ones_q  <= '0;
         eop_q   <= '0;
         last_q  <= 1'b0;
      end else begin
         state_q <= state_n;
         ones_q  <= ones_n;
         eop_q   <= eop_n;
         last_q  <= last_n;
      end
   end

   usb_nrzi_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (sh_load),
      .load_data_i (sh_data),
      .shift_i     (sh_shift),
      .bit_o       (sh_bit),
      .empty_o     (sh_empty)
   );

   usb_nrzi_line_enc u_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_i   (cmd),
      .bit_i   (cmd_bit),
      .first_i (cmd_first),
      .level_o (tx_level),
      .se0_o   (tx_se0),
      .oe_o    (tx_oe)
   );

   // run of emitted ones, tracked from the line command stream
   logic [ONES_W:0] run_q;
   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= '0;
      else if (cmd == CMD_BIT)
         run_q <= cmd_bit ? ((cmd_first ? '0 : run_q) + 1'b1) : '0;
   end

   AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= (ONES_W+1)'(STUFF_LEN)); // R5
   AST_STUFF_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_BIT && !cmd_bit && !cmd_first && run_q == (ONES_W+1)'(STUFF_LEN)) |-> !in_ready); // R6
   AST_QUIET_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> ($stable(tx_level) && $stable(tx_se0) && $stable(tx_oe))); // R10
   AST_OE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_oe |-> busy); // R9
endmodule

// File: tb/sim_usb_nrzi_tx.sv
module sim_usb_nrzi_tx;
   localparam int CLK_PERIOD = 10;
   localparam int MAXT = 160;
   localparam int K_SYNC = 0, K_DATA = 1, K_STUFF = 2, K_SE0 = 3, K_J = 4, K_OFF = 5;

   logic       clk = 1'b0;
   logic       rst_n, bit_en, in_valid, in_last;
   logic [7:0] in_data;
   logic       in_ready, tx_level, tx_se0, tx_oe, busy;

   int errors = 0;
   int checks = 0;

   int   ex_kind [MAXT];
   logic ex_lvl  [MAXT];
   logic ex_rdy  [MAXT];
   int   ex_n;
   logic [7:0] pb [8];
   int   pn;

   always #(CLK_PERIOD/2) clk = ~clk;

   usb_nrzi_tx u0 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
      .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
      .tx_level(tx_level), .tx_se0(tx_se0), .tx_oe(tx_oe), .busy(busy)
   );

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic push(input int k, input logic lvl, input logic rdy);
      ex_kind[ex_n] = k;
      ex_lvl[ex_n]  = lvl;
      ex_rdy[ex_n]  = rdy;
      ex_n++;
   endtask

   // reference stream from the requirements
   task automatic build(input bit use_last);
      logic lvl;
      int   ones;
      logic b;
      ex_n = 0;
      lvl  = 1'b1;
      ones = 0;
      for (int i = 0; i < 8; i++) begin
         b = (i == 7);
         lvl = lvl ^ ~b;
         push(K_SYNC, lvl, 1'b0);
         ones = b ? ones + 1 : 0;
      end
      for (int j = 0; j < pn; j++) begin
         for (int i = 0; i < 8; i++) begin
            if (ones == 6) begin
               lvl = ~lvl;
               push(K_STUFF, lvl, 1'b0);
               ones = 0;
            end
            b = pb[j][i];
            lvl = lvl ^ ~b;
            push(K_DATA, lvl, i == 0);
            ones = b ? ones + 1 : 0;
         end
      end
      if (ones == 6) begin
         lvl = ~lvl;
         push(K_STUFF, lvl, 1'b0);
      end
      push(K_SE0, 1'b0, !use_last);
      push(K_SE0, 1'b0, 1'b0);
      push(K_J, 1'b1, 1'b0);
      push(K_OFF, 1'b1, 1'b0);
   endtask

   task automatic run_packet(input bit use_last);
      int   idx;
      bit   acc;
      int   g;
      logic s_lvl, s_se0, s_oe;
      string rq;
      build(use_last);
      idx = 0;
      for (int t = 0; t < ex_n; t++) begin
         bit_en   = 1'b1;
         in_valid = (idx < pn);
         in_data  = (idx < pn) ? pb[idx] : 8'($urandom);
         in_last  = use_last && (idx == pn - 1);
         #1;
         rq = (ex_kind[t] == K_STUFF) ? "R6" :
              (ex_kind[t] == K_SE0 && ex_rdy[t]) ? "R8" : "R3";
         check(in_ready == ex_rdy[t], rq, "in_ready", int'(in_ready), int'(ex_rdy[t]));
         acc = in_ready && in_valid;
         @(posedge clk);
         if (acc) idx++;
         @(negedge clk);
         case (ex_kind[t])
            K_SYNC:  rq = "R2";
            K_DATA:  rq = "R4";
            K_STUFF: rq = "R5";
            default: rq = "R7";
         endcase
         if (ex_kind[t] == K_OFF)
            check(tx_oe == 1'b0, rq, "tx_oe", int'(tx_oe), 0);
         else
            check({tx_oe, tx_se0, tx_level} == {1'b1, ex_kind[t] == K_SE0, ex_lvl[t]},
                  rq, "oe/se0/level", int'({tx_oe, tx_se0, tx_level}),
                  int'({1'b1, ex_kind[t] == K_SE0, ex_lvl[t]}));
         check(busy == (ex_kind[t] != K_OFF), "R9", "busy", int'(busy),
               int'(ex_kind[t] != K_OFF));
         g = $urandom % 3;
         if (g != 0) begin
            bit_en = 1'b0;
            s_lvl = tx_level; s_se0 = tx_se0; s_oe = tx_oe;
            repeat (g) @(negedge clk);
            #1;
            check({tx_oe, tx_se0, tx_level, in_ready} == {s_oe, s_se0, s_lvl, 1'b0},
                  "R10", "hold without tick", int'({tx_oe, tx_se0, tx_level, in_ready}),
                  int'({s_oe, s_se0, s_lvl, 1'b0}));
            @(negedge clk);
         end
      end
      check(idx == pn, "R3", "bytes taken", idx, pn);
      // idle ticks with no offer start nothing
      bit_en   = 1'b1;
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      check({tx_oe, busy} == 2'b00, "R2", "idle stays quiet", int'({tx_oe, busy}), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R9 watchdog: actual=timeout expected=finished");
      summary();
      $finish;
   end

   initial begin
      int r;
      void'($urandom(32'h5eed_0042));
      rst_n = 1'b0; bit_en = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
      repeat (3) @(negedge clk);
      bit_en = 1'b1; in_valid = 1'b1;
      @(negedge clk);
      #1;
      check({tx_oe, tx_se0, tx_level, busy, in_ready} == 5'b00100, "R1", "in reset",
            int'({tx_oe, tx_se0, tx_level, busy, in_ready}), 4);
      bit_en = 1'b0; in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check({tx_oe, tx_se0, tx_level, busy, in_ready} == 5'b00100, "R1", "after reset",
            int'({tx_oe, tx_se0, tx_level, busy, in_ready}), 4);

      // six trailing ones: inserted zero before the closing sequence
      pb[0] = 8'hFC; pn = 1; run_packet(1'b1);
      // run continues from the sync byte's final one
      pb[0] = 8'h1F; pb[1] = 8'hA5; pn = 2; run_packet(1'b1);
      // inserted zero on the byte handoff tick
      pb[0] = 8'hFC; pb[1] = 8'h01; pn = 2; run_packet(1'b1);
      pb[0] = 8'hFF; pb[1] = 8'hFF; pb[2] = 8'hFF; pn = 3; run_packet(1'b1);
      // source runs dry without a last marker
      pb[0] = 8'h5A; pb[1] = 8'h3C; pn = 2; run_packet(1'b0);
      pb[0] = 8'h00; pn = 1; run_packet(1'b1);

      for (int k = 0; k < 25; k++) begin
         pn = 1 + ($urandom % 6);
         for (int j = 0; j < pn; j++) begin
            r = $urandom % 4;
            case (r)
               0: pb[j] = 8'hFF;
               1: pb[j] = 8'hFF << ($urandom % 8);
               2: pb[j] = 8'hFF >> ($urandom % 8);
               default: pb[j] = 8'($urandom);
            endcase
         end
         run_packet(($urandom % 5) != 0);
      end

      summary();
      $finish;
   end
endmodule